// File: doc/BRIEF.md
# JTAG Scan Sequencer

This block is a host-side JTAG master. One request shifts a chosen number of bits through either the instruction-register path or the data-register path of a single TAP. The same pass collects the bits that come back on `tdo`. Each scan starts and ends in Run-Test/Idle. The block can also be asked to return the TAP to a known state: it drives Test-Logic-Reset and then moves on to Run-Test/Idle.

Outgoing bits arrive as a byte stream. Stream byte k carries scan bits 8k..8k+7, with bit 8k at position 0, and bit 0 of the scan is shifted first. Captured bits leave as a byte stream in the same packing.

Both streams follow valid/ready rules. A producer that keeps `tx_valid` low, or a consumer that keeps `rx_ready` low, stalls the block by freezing `tck` in its current phase. No bit is lost or repeated while it is stalled. A byte offered on `rx_data` stays unchanged until it is taken. `tck` runs at the system clock divided by 2*(`half_div`+1).

Top module: `jtag_scan_master`

## Requirements
- R1: `sel_ir`=0 reaches Shift-DR from Run-Test/Idle with TMS 1,0,0, and `sel_ir`=1 reaches Shift-IR with TMS 1,1,0,0. A scan of N bits therefore takes N+5 `tck` rising edges on the data path and N+6 on the instruction path.
- R2: `len_bits` is the scan length in bits. Any value from 1 up to 2^LEN_W-1 is accepted, and exactly that many bits are shifted.
- R3: Scan bit i is sent as bit i%8 of the i/8-th byte taken from the tx stream, and bit 0 is sent first. Exactly ceil(N/8) tx bytes are consumed.
- R4: Bit i received on `tdo` is placed at bit i%8 of the i/8-th rx byte, so the first received bit lands in byte 0 bit 0. Exactly ceil(N/8) rx bytes are produced, and the unused upper bits of a partial last byte are 0.
- R5: TMS is 1 together with the last data bit, so the TAP passes Exit1 and Update and stops in Run-Test/Idle. While the block is idle, `tck` and `tms` are 0.
- R6: `tdi` and `tms` change only when `tck` falls and hold steady while `tck` is high. `tdo` is sampled at each rising edge of `tck`.
- R7: A request with `len_bits`=0 and `tap_reset`=0 produces no `tck` edge, consumes no tx byte, and ends with `done` and `ok`=0.
- R8: A request with `tap_reset`=1 drives five `tck` cycles with TMS=1 and then one with TMS=0. It moves no data, ends in Run-Test/Idle and reports `ok`=1.
- R9: While running without a stall, each `tck` phase lasts `half_div`+1 clock cycles. The divisor is sampled at `start`.
- R10: `tx_ready` is high only while a tx byte is being fetched, and only in the cycle that byte is used. Once `rx_valid` is high, `rx_valid` and `rx_data` hold until `rx_ready`. No `tck` rising edge occurs while an rx byte is waiting.
- R11: `done` is a one-cycle pulse at the end of every request. `ok`=1 after each scan of nonzero length, and it keeps its value until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| tap_reset | input | 1 | With start: reset the TAP instead of scanning |
| sel_ir | input | 1 | With start: 1 = instruction path, 0 = data path |
| len_bits | input | LEN_W | With start: scan length in bits |
| half_div | input | DIV_W | With start: tck phase length minus one, in clock cycles |
| tx_data | input | 8 | Outgoing byte |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Outgoing byte taken this cycle |
| rx_data | output | 8 | Captured byte |
| rx_valid | output | 1 | Captured byte available |
| rx_ready | input | 1 | Consumer takes the captured byte |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to the device |
| tdo | input | 1 | JTAG data from the device |
| done | output | 1 | One-cycle end-of-request pulse |
| ok | output | 1 | Result of the last request |

## Verification
A wrong TMS walk or a wrong end-of-scan count shows up at once in the TAP model the bench keeps. The model ends in the wrong state, and the number of `tck` rising edges differs from N+5 or N+6 when `done` arrives. A fault in the bit index or in the byte hand-off corrupts the first byte boundary it meets. It therefore shows up as soon as the captured stream or the model's shifted register is compared after that request. Phase and hold faults are visible within one `tck` period: a pin that moves while `tck` is high, a high phase of the wrong length, or an rx byte that changes or is overrun while it waits.

// File: rtl/jtag_scan_pkg.sv
package jtag_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WALK,
    ST_SHIFT,
    ST_DONE
  } scan_st_t;

  localparam int WALK_W = 6;

  // TMS walks, bit 0 goes out first
  localparam logic [WALK_W-1:0] WALK_RESET = 6'b011111;
  localparam logic [2:0]        WALK_RESET_N = 3'd6;
  localparam logic [WALK_W-1:0] WALK_TO_DR = 6'b000001;
  localparam logic [2:0]        WALK_TO_DR_N = 3'd3;
  localparam logic [WALK_W-1:0] WALK_TO_IR = 6'b000011;
  localparam logic [2:0]        WALK_TO_IR_N = 3'd4;
  localparam logic [WALK_W-1:0] WALK_HOME = 6'b000001;
  localparam logic [2:0]        WALK_HOME_N = 3'd2;
endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] half_div,
  output logic             tck,
  output logic             at_lim,
  output logic             rise_ev,
  output logic             fall_ev
);
  localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  assign at_lim  = (cnt == half_div);
  assign rise_ev = run && at_lim && !hold && !tck;
  assign fall_ev = run && at_lim && !hold && tck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (at_lim) begin
      if (!hold) begin
        cnt <= '0;
        tck <= ~tck;
      end
    end else begin
      cnt <= cnt + CNT_ONE;
    end
  end

  // R9: phase may only end when the count has reached its limit
  p_phase_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !at_lim) |=> $stable(tck));

  // R9: a stall freezes the current phase
  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && hold) |=> $stable(tck));
endmodule

// File: rtl/jtag_rx_pack.sv
module jtag_rx_pack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic [2:0] idx,
  input  logic       last,
  input  logic       tdo,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid
);
  logic [7:0] acc;
  logic [7:0] merged;

  always_comb begin
    merged      = acc;
    merged[idx] = tdo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (cap) begin
        if (last) begin
          rx_data  <= merged;
          rx_valid <= 1'b1;
          acc      <= '0;
        end else begin
          acc <= merged;
        end
      end
    end
  end

  // R10: offered byte holds until taken
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R10: no capture while a byte is still waiting
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> !rx_valid);
endmodule

// File: rtl/jtag_scan_master.sv
module jtag_scan_master
  import jtag_scan_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tap_reset,
  input  logic             sel_ir,
  input  logic [LEN_W-1:0] len_bits,
  input  logic [DIV_W-1:0] half_div,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             tck,
  output logic             tms,
  output logic             tdi,
  input  logic             tdo,
  output logic             done,
  output logic             ok
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

  scan_st_t          st;
  logic              ir_q;
  logic [DIV_W-1:0]  div_q;
  logic [WALK_W-1:0] wpat;
  logic [2:0]        wcnt;
  logic              to_shift;
  logic [7:0]        sh_tx;
  logic [2:0]        bcnt;
  logic [2:0]        nxt_idx;
  logic [LEN_W-1:0]  rem;
  logic              tms_q, tdi_q, ok_q;

  logic run, hold, need_byte, last_bit;
  logic at_lim, rise_ev, fall_ev;

  assign nxt_idx   = bcnt + 3'd1;
  assign last_bit  = (rem == LEN_ONE);
  assign run       = (st == ST_WALK) || (st == ST_SHIFT);
  assign need_byte = (st == ST_SHIFT) && tck && (bcnt == 3'd7) && !last_bit;
  assign hold      = (need_byte && !tx_valid) || (!tck && rx_valid);
  assign tx_ready  = (st == ST_FETCH) || (need_byte && at_lim);
  assign tms       = tms_q;
  assign tdi       = tdi_q;
  assign done      = (st == ST_DONE);
  assign ok        = ok_q;

  jtag_tck_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .hold    (hold),
    .half_div(div_q),
    .tck     (tck),
    .at_lim  (at_lim),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  jtag_rx_pack u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (rise_ev && (st == ST_SHIFT)),
    .idx     (bcnt),
    .last    ((bcnt == 3'd7) || last_bit),
    .tdo     (tdo),
    .rx_ready(rx_ready),
    .rx_data (rx_data),
    .rx_valid(rx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ir_q     <= 1'b0;
      div_q    <= '0;
      wpat     <= '0;
      wcnt     <= '0;
      to_shift <= 1'b0;
      sh_tx    <= '0;
      bcnt     <= '0;
      rem      <= '0;
      tms_q    <= 1'b0;
      tdi_q    <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          div_q <= half_div;
          ir_q  <= sel_ir;
          if (tap_reset) begin
            wpat     <= WALK_RESET;
            wcnt     <= WALK_RESET_N;
            to_shift <= 1'b0;
            tms_q    <= WALK_RESET[0];
            st       <= ST_WALK;
          end else if (len_bits == '0) begin
            ok_q <= 1'b0;
            st   <= ST_DONE;
          end else begin
            rem <= len_bits;
            st  <= ST_FETCH;
          end
        end
        ST_FETCH: if (tx_valid) begin
          sh_tx    <= tx_data;
          bcnt     <= '0;
          wpat     <= ir_q ? WALK_TO_IR : WALK_TO_DR;
          wcnt     <= ir_q ? WALK_TO_IR_N : WALK_TO_DR_N;
          to_shift <= 1'b1;
          tms_q    <= 1'b1;
          st       <= ST_WALK;
        end
        ST_WALK: if (fall_ev) begin
          if (wcnt == 3'd1) begin
            if (to_shift) begin
              tms_q <= last_bit;
              tdi_q <= sh_tx[0];
              st    <= ST_SHIFT;
            end else begin
              tms_q <= 1'b0;
              ok_q  <= 1'b1;
              st    <= ST_DONE;
            end
          end else begin
            wpat  <= wpat >> 1;
            tms_q <= wpat[1];
            wcnt  <= wcnt - 3'd1;
          end
        end
        ST_SHIFT: if (fall_ev) begin
          if (last_bit) begin
            wpat     <= WALK_HOME;
            wcnt     <= WALK_HOME_N;
            to_shift <= 1'b0;
            tms_q    <= WALK_HOME[0];
            tdi_q    <= 1'b0;
            st       <= ST_WALK;
          end else begin
            rem   <= rem - LEN_ONE;
            bcnt  <= nxt_idx;
            tms_q <= (rem == LEN_TWO);
            if (bcnt == 3'd7) begin
              sh_tx <= tx_data;
              tdi_q <= tx_data[0];
            end else begin
              tdi_q <= sh_tx[nxt_idx];
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: quiet pins while idle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!tck && !tms));

  // R6: pins hold through the high phase
  p_pins_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && !fall_ev) |=> ($stable(tdi) && $stable(tms)));

  // R7: zero length finishes at once with failure
  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && start && !tap_reset && (len_bits == '0)) |=> (done && !ok));

  // R10: mid-scan byte taken only on the falling edge that uses it
  p_tx_on_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && (st == ST_SHIFT)) |-> fall_ev);

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_jtag_scan_master.sv
`timescale 1ns/1ps
module sim_jtag_scan_master;
  localparam int LEN_W = 16;
  localparam int DIV_W = 8;
  localparam logic [63:0] DR_CAPV = 64'hC3A5_96F0_1E2D_784B;
  localparam logic [7:0]  IR_CAPV = 8'hB1;

  typedef enum logic [3:0] {
    T_TLR, T_RTI, T_SDS, T_CDR, T_SHDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
    T_SIS, T_CIR, T_SHIR, T_E1IR, T_PIR, T_E2IR, T_UIR
  } tap_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tap_reset = 1'b0, sel_ir = 1'b0;
  logic [LEN_W-1:0] len_bits = '0;
  logic [DIV_W-1:0] half_div = '0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic tx_ready, rx_valid, tck, tms, tdi, tdo, done, ok;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  jtag_scan_master #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_reset(tap_reset),
    .sel_ir(sel_ir), .len_bits(len_bits), .half_div(half_div),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .done(done), .ok(ok)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit c, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural TAP device
  tap_t ts = T_TLR;
  logic [63:0] dreg = '0;
  logic [7:0]  ireg = '0;
  assign tdo = (ts == T_SHDR) ? dreg[0] : (ts == T_SHIR) ? ireg[0] : 1'b0;

  function automatic tap_t tap_next(tap_t s, logic m);
    case (s)
      T_TLR:  return m ? T_TLR  : T_RTI;
      T_RTI:  return m ? T_SDS  : T_RTI;
      T_SDS:  return m ? T_SIS  : T_CDR;
      T_CDR:  return m ? T_E1DR : T_SHDR;
      T_SHDR: return m ? T_E1DR : T_SHDR;
      T_E1DR: return m ? T_UDR  : T_PDR;
      T_PDR:  return m ? T_E2DR : T_PDR;
      T_E2DR: return m ? T_UDR  : T_SHDR;
      T_UDR:  return m ? T_SDS  : T_RTI;
      T_SIS:  return m ? T_TLR  : T_CIR;
      T_CIR:  return m ? T_E1IR : T_SHIR;
      T_SHIR: return m ? T_E1IR : T_SHIR;
      T_E1IR: return m ? T_UIR  : T_PIR;
      T_PIR:  return m ? T_E2IR : T_PIR;
      T_E2IR: return m ? T_UIR  : T_SHIR;
      default: return m ? T_SDS : T_RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (ts == T_CDR) dreg <= DR_CAPV;
    if (ts == T_CIR) ireg <= IR_CAPV;
    if (ts == T_SHDR) dreg <= {tdi, dreg[63:1]};
    if (ts == T_SHIR) ireg <= {tdi, ireg[7:1]};
    ts <= tap_next(ts, tms);
  end

  // Stream drivers and per-clock monitor
  logic [7:0] tx_mem [0:15];
  logic [7:0] rx_got [0:15];
  int tx_idx = 0, tx_n = 0, rx_n = 0, cyc = 0, rise_cnt = 0, hi_len = 0;
  bit gap = 0, chk_hi = 0, tx_fire = 0;
  int div_now = 0;
  logic p_tck = 0, p_tdi = 0, p_tms = 0, p_rxv = 0, p_rxr = 0;
  logic [7:0] p_rxd = '0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (tx_fire) begin
      tx_idx++;
      tx_fire = 0;
      tx_valid = 1'b0;
    end
    if (!tx_valid) tx_valid = (tx_idx < tx_n) && (!gap || (cyc % 4 == 0));
    tx_data = (tx_idx < 16) ? tx_mem[tx_idx] : 8'h00;
    rx_ready = !gap || (cyc % 3 == 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_tck && tck) begin
        rise_cnt++;
        if (p_rxv) chk(1'b0, "R10 rise while rx byte waiting", 64'(p_rxv), 64'(0));
      end
      if (tck) hi_len++;
      else begin
        if (p_tck && chk_hi) chk(hi_len == div_now + 1, "R9 high phase length", 64'(hi_len), 64'(div_now + 1));
        hi_len = 0;
      end
      if (p_tck && tck && (tdi !== p_tdi || tms !== p_tms))
        chk(1'b0, "R6 pin moved while tck high", 64'({tdi, tms}), 64'({p_tdi, p_tms}));
      if (p_rxv && !p_rxr && !(rx_valid && rx_data == p_rxd))
        chk(1'b0, "R10 rx byte not held", 64'({rx_valid, rx_data}), 64'({1'b1, p_rxd}));
      if (tx_valid && tx_ready) tx_fire = 1;
      if (rx_valid && rx_ready) begin
        if (rx_n < 16) rx_got[rx_n] = rx_data;
        rx_n++;
      end
    end
    p_tck = tck; p_tdi = tdi; p_tms = tms;
    p_rxv = rx_valid; p_rxr = rx_ready; p_rxd = rx_data;
  end

  function automatic logic in_bit(int i);
    return tx_mem[i / 8][i % 8];
  endfunction

  function automatic logic got_bit(int i);
    return rx_got[i / 8][i % 8];
  endfunction

  task automatic run_req(input bit rst_req, input bit ir, input int n, input int div, input bit gp, output bit seen);
    @(negedge clk);
    for (int k = 0; k < 16; k++) tx_mem[k] = 8'h5A ^ 8'((k + 1) * 29) ^ 8'(n);
    tx_idx = 0; rx_n = 0; rise_cnt = 0;
    tx_n = rst_req ? 0 : ((n == 0) ? 1 : (n + 7) / 8);
    gap = gp; chk_hi = !gp; div_now = div;
    @(posedge clk); #1;
    start = 1'b1; tap_reset = rst_req; sel_ir = ir;
    len_bits = LEN_W'(n); half_div = DIV_W'(div);
    @(posedge clk); #1;
    start = 1'b0; tap_reset = 1'b0;
    seen = 0;
    for (int c = 0; c < 20000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    if (!seen) chk(1'b0, "R11 done never seen", 64'(0), 64'(1));
  endtask

  task automatic do_scan(input bit ir, input int n, input int div, input bit gp);
    bit seen, mis, padz;
    int L, nb;
    logic [63:0] capv, fin;
    run_req(1'b0, ir, n, div, gp, seen);
    L = ir ? 8 : 64;
    capv = ir ? {56'h0, IR_CAPV} : DR_CAPV;
    fin  = ir ? {56'h0, ireg} : dreg;
    nb = (n + 7) / 8;
    chk(ok == 1'b1, "R11 ok after scan", 64'(ok), 64'(1));
    chk(rise_cnt == n + (ir ? 6 : 5), "R1 R2 tck rising edges", 64'(rise_cnt), 64'(n + (ir ? 6 : 5)));
    chk(ts == T_RTI, "R5 TAP parked in Run-Test/Idle", 64'(ts), 64'(T_RTI));
    chk(tx_idx == nb, "R3 tx bytes consumed", 64'(tx_idx), 64'(nb));
    chk(rx_n == nb, "R4 rx bytes produced", 64'(rx_n), 64'(nb));
    mis = 0;
    for (int i = 0; i < n; i++)
      if (got_bit(i) !== ((i < L) ? capv[i] : in_bit(i - L))) mis = 1;
    chk(!mis, "R4 R6 captured bit order", 64'(rx_got[0]), 64'(capv[7:0]));
    mis = 0;
    for (int j = 0; j < L; j++)
      if (fin[j] !== (((j + n) < L) ? capv[j + n] : in_bit(j + n - L))) mis = 1;
    chk(!mis, "R3 shifted register content", fin, 64'(0));
    padz = 1;
    for (int i = n; i < nb * 8; i++) if (got_bit(i) !== 1'b0) padz = 0;
    chk(padz, "R4 partial byte padding", 64'(rx_got[nb - 1]), 64'(0));
    @(negedge clk);
    chk(!done && !tck && !tms, "R11 R5 done pulse ends, pins quiet", 64'({done, tck, tms}), 64'(0));
  endtask

  task automatic do_reset_req(input bit from_tlr);
    bit seen;
    run_req(1'b1, 1'b0, 0, 1, 1'b0, seen);
    chk(rise_cnt == 6, from_tlr ? "R8 reset edges from TLR" : "R8 reset edges from idle", 64'(rise_cnt), 64'(6));
    chk(ts == T_RTI, "R8 reset ends in Run-Test/Idle", 64'(ts), 64'(T_RTI));
    chk(ok == 1'b1, "R8 ok after reset", 64'(ok), 64'(1));
    chk(tx_idx == 0, "R8 no tx byte used", 64'(tx_idx), 64'(0));
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk({tck, tms, done, rx_valid, tx_ready} == 5'b0, "R5 reset state", 64'({tck, tms, done, rx_valid, tx_ready}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tck && !tms && !tx_ready, "R5 idle after reset", 64'({tck, tms, tx_ready}), 64'(0));

    do_reset_req(1'b1);
    do_scan(1'b0, 20, 0, 1'b0);   // R1 R2 data path
    do_scan(1'b1, 5, 2, 1'b0);    // R1 instruction path, R9 divider
    do_scan(1'b0, 70, 1, 1'b1);   // R10 back-pressure, long scan
    do_scan(1'b0, 1, 0, 1'b0);    // R2 minimum length
    do_scan(1'b1, 8, 3, 1'b1);    // R4 exact byte
    do_scan(1'b0, 64, 0, 1'b0);   // R3 byte boundaries

    run_req(1'b0, 1'b0, 0, 0, 1'b0, seen);  // R7 zero length
    chk(ok == 1'b0, "R7 zero length reports failure", 64'(ok), 64'(0));
    chk(rise_cnt == 0, "R7 no tck activity", 64'(rise_cnt), 64'(0));
    chk(tx_idx == 0, "R7 offered byte left untaken", 64'(tx_idx), 64'(0));
    chk(ts == T_RTI, "R7 TAP undisturbed", 64'(ts), 64'(T_RTI));

    do_reset_req(1'b0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule